// File: doc/BRIEF.md
# Paired Halfword and High-Word Multiply Unit

This unit is the multiply stage of a DSP-capable processor core. It takes two source words and computes one of several products, selected by a 3-bit operation code. The first group of operations splits each source into two signed halfwords. It forms two halfword products and adds or subtracts them. An exchange option crosses the halves of the second operand. The second group forms the full signed product of the two words and returns the upper word, either truncated or rounded. The last operation multiplies the two words as unsigned values and adds two further unsigned words, giving a 64-bit result.

Each accepted operation returns its result one clock later. A sticky saturation flag records any overflow of the two halfword-sum operations. The flag stays set until the surrounding core clears it. Instruction decode and register writeback live outside this block.

Top module: `hw_dual_mac`

## Requirements
- R1: A result is due exactly one clock edge after `in_valid` is sampled high, and `out_valid` is high in that cycle only. If `in_valid` was low at the previous edge, `out_valid` is low.
- R2: Opcode 0 returns `a[31:16]*b[31:16] + a[15:0]*b[15:0]`. Both products are signed, and the sum is taken modulo 2^32 on `res_lo`.
- R3: Opcodes 0 and 1 set `q_flag` when the signed sum does not fit in 32 bits. The only case that overflows is both products equal to 0x8000*0x8000, which wraps to 0x80000000.
- R4: Opcode 1 returns `a[31:16]*b[15:0] + a[15:0]*b[31:16]`, with signed products.
- R5: Opcode 2 returns `a[31:16]*b[31:16] - a[15:0]*b[15:0]`. Opcode 3 returns `a[31:16]*b[15:0] - a[15:0]*b[31:16]`. Neither of them ever sets `q_flag`.
- R6: Opcode 4 returns bits [63:32] of the signed 64-bit product `a*b`.
- R7: Opcode 5 returns bits [63:32] of the signed product `a*b` plus 0x80000000.
- R8: Opcode 6 returns `{res_hi,res_lo} = a*b + acc_lo + acc_hi`, with all four values unsigned. The sum never exceeds 2^64-1.
- R9: `res_hi` is zero after every opcode except 6. Opcode 7 is reserved and returns zero on `res_lo`.
- R10: `q_flag` is sticky. `q_clear` clears it at the next edge, but a new overflow in the same cycle wins and leaves it set.
- R11: While `in_valid` is low, `res_lo` and `res_hi` keep their values, whatever the other inputs do.
- R12: Reset, active-low and asynchronous, clears `out_valid`, `res_lo`, `res_hi` and `q_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request, sampled each edge |
| op | input | 3 | Operation code (0..7, see requirements) |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| acc_lo | input | 32 | First unsigned addend (opcode 6) |
| acc_hi | input | 32 | Second unsigned addend (opcode 6) |
| q_clear | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result registers updated this cycle |
| res_lo | output | 32 | Result word, low half for opcode 6 |
| res_hi | output | 32 | Upper result word for opcode 6, else zero |
| q_flag | output | 1 | Sticky halfword-sum overflow flag |

## Verification
Every result, `out_valid`, and every change to `q_flag` is due one edge after the inputs that cause it. The bench drives inputs on the falling edge. It lets one rising edge pass, then samples on the following falling edge, so every check reads the value registered from that single request. Checks that a result is held, or that the flag stays put, read the outputs one edge after a cycle with `in_valid` low or with a subtract operation.

// File: rtl/hw_dual_mac_pkg.sv
package hw_dual_mac_pkg;

   typedef enum logic [2:0] {
      OP_DADD   = 3'd0,
      OP_DADDX  = 3'd1,
      OP_DSUB   = 3'd2,
      OP_DSUBX  = 3'd3,
      OP_HI_TR  = 3'd4,
      OP_HI_RND = 3'd5,
      OP_LONG   = 3'd6,
      OP_RSVD   = 3'd7
   } mac_op_e;

   localparam int unsigned OP_W = 3;

endpackage

// File: rtl/hw_dual_pair.sv
// Two signed halfword products, summed or differenced, with optional
// crossing of the second operand's halves.
module hw_dual_pair #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned HALF_W = DATA_W / 2,
   localparam int unsigned PROD_W = 2 * HALF_W
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              exch,
   input  logic              sub,
   output logic [DATA_W-1:0] res,
   output logic              ovf
);

   logic signed [PROD_W-1:0] prod [2];
   logic signed [PROD_W:0]   wide;

   // lane 1 takes the high half of a, lane 0 the low half
   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic signed [HALF_W-1:0] ah;
      logic signed [HALF_W-1:0] bh;
      logic [HALF_W-1:0]        b_same;
      logic [HALF_W-1:0]        b_cross;
      assign ah      = a[g*HALF_W +: HALF_W];
      assign b_same  = b[g*HALF_W +: HALF_W];
      assign b_cross = b[(1-g)*HALF_W +: HALF_W];
      assign bh      = exch ? b_cross : b_same;
      assign prod[g] = ah * bh;
   end

   always_comb begin
      logic signed [PROD_W:0] e1;
      logic signed [PROD_W:0] e0;
      e1 = {prod[1][PROD_W-1], prod[1]};
      e0 = {prod[0][PROD_W-1], prod[0]};
      wide = sub ? (e1 - e0) : (e1 + e0);
   end

   assign res = wide[DATA_W-1:0];
   assign ovf = wide[PROD_W] ^ wide[PROD_W-1];

endmodule

// File: rtl/hw_hiword_mul.sv
// Signed full-width product, upper word returned, optionally rounded.
module hw_hiword_mul #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned FULL_W = 2 * DATA_W
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              round,
   output logic [DATA_W-1:0] hi
);

   localparam logic [FULL_W-1:0] RND_K = {{DATA_W{1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};

   logic signed [DATA_W-1:0] sa;
   logic signed [DATA_W-1:0] sb;
   logic signed [FULL_W-1:0] prod;
   logic [FULL_W-1:0]        biased;

   assign sa     = a;
   assign sb     = b;
   assign prod   = sa * sb;
   assign biased = prod + (round ? RND_K : '0);
   assign hi     = biased[FULL_W-1:DATA_W];

endmodule

// File: rtl/hw_long_umac.sv
// Unsigned product plus two addends, full double width, cannot overflow.
module hw_long_umac #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned FULL_W = 2 * DATA_W
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] c,
   input  logic [DATA_W-1:0] d,
   output logic [FULL_W-1:0] res
);

   logic [FULL_W-1:0] ea, eb, ec, ed;

   assign ea  = {{DATA_W{1'b0}}, a};
   assign eb  = {{DATA_W{1'b0}}, b};
   assign ec  = {{DATA_W{1'b0}}, c};
   assign ed  = {{DATA_W{1'b0}}, d};
   assign res = ea * eb + ec + ed;

endmodule

// File: rtl/hw_dual_mac.sv
module hw_dual_mac
   import hw_dual_mac_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] acc_lo,
   input  logic [DATA_W-1:0] acc_hi,
   input  logic              q_clear,
   output logic              out_valid,
   output logic [DATA_W-1:0] res_lo,
   output logic [DATA_W-1:0] res_hi,
   output logic              q_flag
);

   localparam int unsigned FULL_W = 2 * DATA_W;

   if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
      $error("hw_dual_mac: DATA_W must be even and at least 4");
   end

   mac_op_e           op_e;
   logic              is_add, is_sub, is_exch, is_pair;
   logic [DATA_W-1:0] pair_res, hi_res;
   logic              pair_ovf, q_set;
   logic [FULL_W-1:0] long_res;
   logic [DATA_W-1:0] nxt_lo, nxt_hi;

   assign op_e    = mac_op_e'(op);
   assign is_add  = (op_e == OP_DADD) || (op_e == OP_DADDX);
   assign is_sub  = (op_e == OP_DSUB) || (op_e == OP_DSUBX);
   assign is_exch = (op_e == OP_DADDX) || (op_e == OP_DSUBX);
   assign is_pair = is_add || is_sub;

   hw_dual_pair #(.DATA_W(DATA_W)) u_pair (
      .a(src_a), .b(src_b), .exch(is_exch), .sub(is_sub),
      .res(pair_res), .ovf(pair_ovf)
   );

   hw_hiword_mul #(.DATA_W(DATA_W)) u_hiword (
      .a(src_a), .b(src_b), .round(op_e == OP_HI_RND), .hi(hi_res)
   );

   hw_long_umac #(.DATA_W(DATA_W)) u_long (
      .a(src_a), .b(src_b), .c(acc_lo), .d(acc_hi), .res(long_res)
   );

   always_comb begin
      nxt_lo = '0;
      nxt_hi = '0;
      if (is_pair) begin
         nxt_lo = pair_res;
      end else if (op_e == OP_HI_TR || op_e == OP_HI_RND) begin
         nxt_lo = hi_res;
      end else if (op_e == OP_LONG) begin
         nxt_lo = long_res[DATA_W-1:0];
         nxt_hi = long_res[FULL_W-1:DATA_W];
      end
   end

   assign q_set = in_valid && is_add && pair_ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_lo    <= '0;
         res_hi    <= '0;
         q_flag    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_lo <= nxt_lo;
            res_hi <= nxt_hi;
         end
         q_flag <= (q_flag && !q_clear) || q_set;
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r5_sub_no_q: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_flag && in_valid && (op == 3'd2 || op == 3'd3)) |=> !q_flag);
   a_r9_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op != 3'd6) |=> (res_hi == '0));
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (q_flag && !q_clear) |=> q_flag);
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (q_clear && !(in_valid && (op == 3'd0 || op == 3'd1))) |=> !q_flag);
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_lo) && $stable(res_hi)));

endmodule

// File: tb/hw_dual_mac_bench.sv
module hw_dual_mac_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = '0;
   logic [31:0] src_a = '0, src_b = '0, acc_lo = '0, acc_hi = '0;
   logic        q_clear = 1'b0;
   logic        out_valid, q_flag;
   logic [31:0] res_lo, res_hi;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hw_dual_mac u_hw_dual_mac (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .src_a(src_a), .src_b(src_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
      .q_clear(q_clear), .out_valid(out_valid), .res_lo(res_lo),
      .res_hi(res_hi), .q_flag(q_flag)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference models from the requirements
   function automatic logic [32:0] ref_pair(input logic [2:0] o, input logic [31:0] a,
                                            input logic [31:0] b);
      longint ah, al, bh, bl, p1, p0, s;
      ah = longint'($signed(a[31:16])); al = longint'($signed(a[15:0]));
      bh = longint'($signed(b[31:16])); bl = longint'($signed(b[15:0]));
      if (o == 3'd1 || o == 3'd3) begin p1 = ah * bl; p0 = al * bh; end
      else begin p1 = ah * bh; p0 = al * bl; end
      s = (o == 3'd2 || o == 3'd3) ? p1 - p0 : p1 + p0;
      ref_pair = {(s > 64'sd2147483647 || s < -64'sd2147483648), s[31:0]};
   endfunction

   function automatic logic [31:0] ref_hi(input logic rnd, input logic [31:0] a,
                                          input logic [31:0] b);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b));
      if (rnd) p = p + 64'sh80000000;
      ref_hi = p[63:32];
   endfunction

   task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] cl, input logic [31:0] ch, input logic clr);
      @(negedge clk);
      in_valid = 1'b1; op = o; src_a = a; src_b = b;
      acc_lo = cl; acc_hi = ch; q_clear = clr;
      @(negedge clk);
      in_valid = 1'b0; q_clear = 1'b0;
   endtask

   task automatic clear_q();
      @(negedge clk);
      q_clear = 1'b1;
      @(negedge clk);
      q_clear = 1'b0;
   endtask

   task automatic t_reset();
      chk("R12 out_valid", 64'(out_valid), 64'd0);
      chk("R12 res_lo", 64'(res_lo), 64'd0);
      chk("R12 res_hi", 64'(res_hi), 64'd0);
      chk("R12 q_flag", 64'(q_flag), 64'd0);
   endtask

   task automatic t_pair(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
      logic [32:0] e;
      string tag;
      e = ref_pair(o, a, b);
      tag = (o == 3'd0) ? "R2" : (o == 3'd1) ? "R4" : "R5";
      clear_q();
      issue(o, a, b, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
      chk({tag, " result"}, 64'(res_lo), 64'(e[31:0]));
      chk("R1 out_valid", 64'(out_valid), 64'd1);
      chk("R9 res_hi zero", 64'(res_hi), 64'd0);
      if (o == 3'd2 || o == 3'd3) chk("R5 no q", 64'(q_flag), 64'd0);
      else chk("R3 q", 64'(q_flag), 64'(e[32]));
   endtask

   task automatic t_hi(input logic rnd, input logic [31:0] a, input logic [31:0] b);
      issue(rnd ? 3'd5 : 3'd4, a, b, 32'h0, 32'h0, 1'b0);
      chk(rnd ? "R7 rounded" : "R6 truncated", 64'(res_lo), 64'(ref_hi(rnd, a, b)));
      chk("R9 res_hi zero", 64'(res_hi), 64'd0);
   endtask

   task automatic t_long(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] cl, input logic [31:0] ch);
      logic [63:0] e;
      e = 64'(a) * 64'(b) + 64'(cl) + 64'(ch);
      issue(3'd6, a, b, cl, ch, 1'b0);
      chk("R8 long", {res_hi, res_lo}, e);
   endtask

   task automatic t_reserved();
      issue(3'd7, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1, 32'h2, 1'b0);
      chk("R9 reserved lo", 64'(res_lo), 64'd0);
      chk("R9 reserved hi", 64'(res_hi), 64'd0);
   endtask

   task automatic t_hold();
      issue(3'd4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0);
      @(negedge clk);
      op = 3'd6; src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF; acc_lo = 32'hFFFF_FFFF;
      @(negedge clk);
      chk("R11 hold lo", 64'(res_lo), 64'h3FFF_FFFF);
      chk("R11 hold hi", 64'(res_hi), 64'd0);
      chk("R1 idle valid", 64'(out_valid), 64'd0);
   endtask

   task automatic t_sticky();
      clear_q();
      issue(3'd0, 32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0, 1'b0);
      chk("R3 overflow wrap", 64'(res_lo), 64'h8000_0000);
      chk("R3 q set", 64'(q_flag), 64'd1);
      issue(3'd2, 32'h1, 32'h1, 32'h0, 32'h0, 1'b0);
      chk("R10 sticky", 64'(q_flag), 64'd1);
      clear_q();
      chk("R10 cleared", 64'(q_flag), 64'd0);
      issue(3'd1, 32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0, 1'b1);
      chk("R10 set wins over clear", 64'(q_flag), 64'd1);
      clear_q();
      issue(3'd3, 32'h8000_7FFF, 32'h8000_8000, 32'h0, 32'h0, 1'b0);
      chk("R5 sub corner no q", 64'(q_flag), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_pair(3'd0, 32'h0003_FFFE, 32'h0005_0007);
      t_pair(3'd0, 32'h8000_8000, 32'h8000_8000);
      t_pair(3'd0, 32'h7FFF_8000, 32'h7FFF_8000);
      t_pair(3'd1, 32'h0002_0003, 32'h0011_0013);
      t_pair(3'd1, 32'h8000_8000, 32'h8000_8000);
      t_pair(3'd2, 32'h7FFF_8000, 32'h8000_7FFF);
      t_pair(3'd2, 32'hFFFF_0004, 32'h0009_FFFD);
      t_pair(3'd3, 32'h0002_0003, 32'h0011_0013);
      t_pair(3'd3, 32'h7FFF_8000, 32'h7FFF_7FFF);
      t_hi(1'b0, 32'h8000_0000, 32'h8000_0000);
      t_hi(1'b0, 32'hFFFF_FFFF, 32'h0000_0001);
      t_hi(1'b0, 32'h1234_5678, 32'h8765_4321);
      t_hi(1'b1, 32'h0000_0001, 32'h8000_0000);
      t_hi(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      t_hi(1'b1, 32'hFFFF_FFFF, 32'h8000_0000);
      t_long(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      t_long(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0001, 32'h8000_0000);
      t_long(32'h0, 32'h0, 32'hFFFF_FFFF, 32'h1);
      t_reserved();
      t_hold();
      t_sticky();
      for (int i = 0; i < 40; i++) begin
         logic [31:0] ra, rb;
         logic [2:0]  ro;
         ra = $urandom(); rb = $urandom(); ro = 3'($urandom_range(0, 5));
         if (ro < 3'd4) t_pair(ro, ra, rb);
         else t_hi(ro[0], ra, rb);
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule